// File: doc/BRIEF.md
# Page Commit Unit

This block sits behind a serial memory's bus protocol engine. It collects the data bytes of a write transfer into a small page buffer. On the stop condition it copies them into the memory array during a self-timed write cycle. The protocol engine first hands over the word address with a load strobe. It then presents each data byte with a strobe, and finally pulses the stop strobe. While `busy` is high the engine must withhold acknowledges, and the unit ignores all further strobes.

Writes never leave the page selected by the word address. Only the low address bits advance, so a long burst wraps to the page start and replaces the oldest buffered bytes. Two conditions decide whether a buffered page may be committed. The first is the level of the transmit-clock pin. The second is a write-protect input, which only takes effect once a one-time fuse has been set by storing to the top address.

Top module: `page_commit_unit`

## Requirements
- R1: No array write occurs before the stop strobe. Only bytes strobed after the most recent address load are committed, and a new address load discards any bytes buffered before it.
- R2: After each accepted byte, the low 3 address bits advance by one modulo 8 and the upper 4 bits stay fixed. A burst starting at page offset k therefore wraps from offset 7 to offset 0 of the same page.
- R3: When more than 8 bytes arrive, each page slot holds the last byte strobed into it, so only the final eight bytes are stored.
- R4: An accepted stop makes `busy` high from the next cycle for exactly WR_CYCLES cycles. While `busy` is high, byte, load and stop strobes are ignored.
- R5: The transmit-clock level is sampled at every data byte. If it was low at any byte of the transfer, the stop commits nothing and `busy` stays low.
- R6: `fuse_set` is 0 after reset. It becomes 1 after any commit writes address 0x7F, and it never returns to 0 except through reset.
- R7: A commit is allowed when the clock condition holds and the fuse is clear. Once the fuse is set, a commit is allowed only when `wp_lvl` is 1 at the stop; a low `wp_lvl` blocks the commit.
- R8: Each received slot is written exactly once, one write per cycle, at address {page, slot}. Slots that received no byte and addresses outside the page are not written.
- R9: A change of `txclk_lvl` while `busy` is high neither shortens the cycle nor cancels any of its writes.
- R10: A stop strobe with no data byte since the address load, or with no preceding address load, leaves `busy` low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Strobe: load word address, open a transfer |
| addr_in | input | 7 | Word address (page in bits 6:3, slot in bits 2:0) |
| byte_vld | input | 1 | Strobe: one received data byte |
| byte_in | input | 8 | Data byte |
| stop_in | input | 1 | Strobe: stop condition seen on the bus |
| txclk_lvl | input | 1 | Level of the transmit-clock pin (1 = write enabled) |
| wp_lvl | input | 1 | Write-protect pin, 1 = writes allowed; tie high when unused |
| mem_we | output | 1 | Array write enable, one cycle per byte |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| fuse_set | output | 1 | Protection fuse state |

## Verification
A table of transfers varies the start offset, the burst length (short, wrapping, longer than a page), the clock level and the protect level. It is applied against a sequence of fuse states, so it distinguishes a wrong wrap point, a wrong overwrite order and a wrong permission decision. Every table entry compares a full shadow image of the array with a model built from the requirements, which catches stray or missing writes. Directed cases cover a clock that dips for one byte only, a clock that drops during busy, strobes arriving during busy, a re-loaded address and an empty stop. These separate a permission that is sampled once from one that is accumulated across the bytes.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Commit permission: clock condition, then fuse-gated write-protect pin.
  function automatic logic pcu_permit(input logic clk_ok, input logic fuse, input logic wp);
    return clk_ok & (~fuse | wp);
  endfunction
endpackage

// File: rtl/pcu_page_buf.sv
module pcu_page_buf #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy,
  input  logic                     addr_load,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     byte_vld,
  input  logic [DATA_W-1:0]        byte_in,
  input  logic                     stop_in,
  input  logic                     txclk_lvl,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic [ADDR_W-PAGE_W-1:0] page_no,
  output logic [(1<<PAGE_W)-1:0]   valid_mask,
  output logic                     clk_ok,
  output logic                     open
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] slot_mem [SLOTS];
  logic [PAGE_W-1:0] ptr_q;
  logic [PG_W-1:0]   page_q;
  logic [SLOTS-1:0]  valid_q;
  logic              clk_ok_q;
  logic              open_q;
  logic              take_byte;

  assign take_byte = !busy && open_q && byte_vld && !addr_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      valid_q  <= '0;
      clk_ok_q <= 1'b1;
      page_q   <= '0;
      ptr_q    <= '0;
    end else if (!busy) begin
      if (addr_load) begin
        open_q   <= 1'b1;
        page_q   <= addr_in[ADDR_W-1:PAGE_W];
        ptr_q    <= addr_in[PAGE_W-1:0];
        valid_q  <= '0;
        clk_ok_q <= 1'b1;
      end else if (byte_vld && open_q) begin
        valid_q[ptr_q] <= 1'b1;
        ptr_q          <= ptr_q + 1'b1;
        clk_ok_q       <= clk_ok_q & txclk_lvl;
      end else if (stop_in && open_q) begin
        open_q <= 1'b0;
      end
    end
  end

  // Data storage without reset so it maps onto distributed/block RAM.
  always_ff @(posedge clk) begin
    if (take_byte) slot_mem[ptr_q] <= byte_in;
  end

  assign rd_data    = slot_mem[rd_idx];
  assign page_no    = page_q;
  assign valid_mask = valid_q;
  assign clk_ok     = clk_ok_q;
  assign open       = open_q;

  a_r4_frozen_in_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(valid_q));
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (rst)
    (open_q && !addr_load) |=> $stable(page_q));
endmodule

// File: rtl/pcu_guard.sv
module pcu_guard (
  input  logic clk,
  input  logic rst,
  input  logic fuse_hit,
  input  logic clk_ok,
  input  logic wp_lvl,
  output logic permit,
  output logic fuse
);
  import pcu_pkg::*;

  logic fuse_q;

  always_ff @(posedge clk) begin
    if (rst)           fuse_q <= 1'b0;
    else if (fuse_hit) fuse_q <= 1'b1;
  end

  assign permit = pcu_permit(clk_ok, fuse_q, wp_lvl);
  assign fuse   = fuse_q;

  a_r6_fuse_sticky: assert property (@(posedge clk) disable iff (rst)
    fuse_q |=> fuse_q);
  a_r7_wp_blocks: assert property (@(posedge clk) disable iff (rst)
    (fuse_q && !wp_lvl) |-> !permit);
endmodule

// File: rtl/pcu_commit_seq.sv
module pcu_commit_seq #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 3,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [(1<<PAGE_W)-1:0]   valid_mask,
  input  logic [ADDR_W-PAGE_W-1:0] page_no,
  input  logic [DATA_W-1:0]        rd_data,
  output logic [PAGE_W-1:0]        rd_idx,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     busy,
  output logic                     fuse_hit
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PAGE_W-1:0] idx;

  assign idx    = cnt_q[PAGE_W-1:0];
  assign rd_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q < CNT_W'(SLOTS) && valid_mask[idx]) begin
          we_q    <= 1'b1;
          addr_q  <= {page_no, idx};
          wdata_q <= rd_data;
        end
        if (cnt_q == CNT_W'(WR_CYCLES - 1)) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign busy      = busy_q;
  assign fuse_hit  = we_q && (addr_q == {ADDR_W{1'b1}});

  // Checker counter: length of each busy window.
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> run_q == CNT_W'(WR_CYCLES));
  a_r8_write_in_cycle: assert property (@(posedge clk) disable iff (rst)
    we_q |-> busy_q);
  a_r8_page_local: assert property (@(posedge clk) disable iff (rst)
    we_q |-> addr_q[ADDR_W-1:PAGE_W] == page_no);
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 3,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_in,
  input  logic              txclk_lvl,
  input  logic              wp_lvl,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              fuse_set
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic [PG_W-1:0]   page_no;
  logic [SLOTS-1:0]  valid_mask;
  logic              clk_ok, open, permit, fuse_hit, start;

  pcu_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .busy(busy), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_in(stop_in), .txclk_lvl(txclk_lvl),
    .rd_idx(rd_idx), .rd_data(rd_data), .page_no(page_no), .valid_mask(valid_mask),
    .clk_ok(clk_ok), .open(open)
  );

  pcu_guard u_guard (
    .clk(clk), .rst(rst), .fuse_hit(fuse_hit), .clk_ok(clk_ok), .wp_lvl(wp_lvl),
    .permit(permit), .fuse(fuse_set)
  );

  assign start = stop_in && !busy && open && !addr_load && (|valid_mask) && permit;

  pcu_commit_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .valid_mask(valid_mask), .page_no(page_no),
    .rd_data(rd_data), .rd_idx(rd_idx), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .fuse_hit(fuse_hit)
  );

  a_r5_gated_no_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(clk_ok));
  a_r10_empty_no_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(|valid_mask));
  a_r1_no_write_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);
endmodule

// File: tb/page_commit_unit_tb_top.sv
module page_commit_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int WR    = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic addr_load = 0, byte_vld = 0, stop_in = 0, txclk_lvl = 1, wp_lvl = 1;
  logic [6:0] addr_in = '0;
  logic [7:0] byte_in = '0;
  logic mem_we, busy, fuse_set;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;

  always #(CLK_P/2) clk = ~clk;

  page_commit_unit #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in), .byte_vld(byte_vld),
    .byte_in(byte_in), .stop_in(stop_in), .txclk_lvl(txclk_lvl), .wp_lvl(wp_lvl),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .fuse_set(fuse_set)
  );

  int checks = 0, fails = 0, wcount = 0;
  logic [7:0] mirror [128];
  logic [7:0] model  [128];

  initial for (int i = 0; i < 128; i++) begin mirror[i] = 8'h00; model[i] = 8'h00; end

  always @(negedge clk) if (!rst && mem_we) begin
    mirror[mem_addr] = mem_wdata;
    wcount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask

  task automatic do_byte(input logic [7:0] d, input logic ck);
    @(negedge clk); byte_vld = 1; byte_in = d; txclk_lvl = ck;
    @(negedge clk); byte_vld = 0; txclk_lvl = 1;
  endtask

  // Pulse stop; returns busy seen one cycle later.
  task automatic do_stop(output logic b);
    @(negedge clk); stop_in = 1;
    @(negedge clk); stop_in = 0; b = busy;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  function automatic int mism();
    int n = 0;
    for (int i = 0; i < 128; i++) if (mirror[i] !== model[i]) n++;
    return n;
  endfunction

  // {addr[21:15], nbytes[14:11], seed[10:3], clk[2], wp[1], exp_commit[0]}
  localparam int NV = 7;
  localparam logic [21:0] VEC [NV] = '{
    {7'h10, 4'd3,  8'hA0, 1'b1, 1'b0, 1'b1},  // R7 fuse clear: wp ignored
    {7'h1E, 4'd5,  8'hB0, 1'b1, 1'b1, 1'b1},  // R2 wrap 1E,1F,18,19,1A
    {7'h23, 4'd10, 8'hC0, 1'b1, 1'b1, 1'b1},  // R3 ten bytes, last eight kept
    {7'h30, 4'd2,  8'hD0, 1'b0, 1'b1, 1'b0},  // R5 clock low
    {7'h7F, 4'd1,  8'hE0, 1'b1, 1'b0, 1'b1},  // R6 sets fuse
    {7'h40, 4'd2,  8'h50, 1'b1, 1'b0, 1'b0},  // R7 fuse set, wp low
    {7'h40, 4'd2,  8'h60, 1'b1, 1'b1, 1'b1}   // R7 fuse set, wp high
  };

  initial begin
    int cyc, w0, nb;
    logic b;
    logic [6:0] a;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R4 reset busy/we", busy, 0);
    chk(fuse_set == 0, "R6 reset fuse", fuse_set, 0);

    for (int v = 0; v < NV; v++) begin
      a  = VEC[v][21:15];
      nb = int'(VEC[v][14:11]);
      wp_lvl = VEC[v][1];
      w0 = wcount;
      do_load(a);
      for (int i = 0; i < nb; i++) do_byte(VEC[v][10:3] + 8'(i), VEC[v][2]);
      chk(wcount == w0, "R1 nothing before stop", wcount - w0, 0);
      if (VEC[v][0])
        for (int i = 0; i < nb; i++)
          model[{a[6:3], 3'(a[2:0] + 3'(i))}] = VEC[v][10:3] + 8'(i);
      do_stop(b);
      chk(b == VEC[v][0], "R5/R7 busy after stop", b, VEC[v][0]);
      wait_idle(cyc);
      chk(cyc == (VEC[v][0] ? WR : 0), "R4 busy length", cyc, VEC[v][0] ? WR : 0);
      chk(wcount - w0 == (VEC[v][0] ? (nb > 8 ? 8 : nb) : 0), "R8 write count",
          wcount - w0, VEC[v][0] ? (nb > 8 ? 8 : nb) : 0);
      chk(mism() == 0, "R2/R3/R8 array image", mism(), 0);
      if (v == 3) chk(fuse_set == 0, "R6 fuse still clear", fuse_set, 0);
      if (v == 4) chk(fuse_set == 1, "R6 fuse set by 0x7F", fuse_set, 1);
    end
    wp_lvl = 1;

    // R5: clock low on the middle byte only
    w0 = wcount;
    do_load(7'h08);
    do_byte(8'h11, 1); do_byte(8'h12, 0); do_byte(8'h13, 1);
    do_stop(b);
    chk(b == 0, "R5 single low byte blocks", b, 0);
    wait_idle(cyc);
    chk(wcount == w0, "R5 no writes", wcount - w0, 0);

    // R9: clock falls during busy; R4: strobes during busy ignored
    w0 = wcount;
    do_load(7'h0C);
    do_byte(8'h21, 1); do_byte(8'h22, 1);
    model[7'h0C] = 8'h21; model[7'h0D] = 8'h22;
    do_stop(b);
    chk(b == 1, "R9 cycle started", b, 1);
    txclk_lvl = 0;
    @(negedge clk); addr_load = 1; addr_in = 7'h60;
    @(negedge clk); addr_load = 0; byte_vld = 1; byte_in = 8'h99;
    @(negedge clk); byte_vld = 0; stop_in = 1;
    @(negedge clk); stop_in = 0;
    cyc = 4;
    while (busy) begin cyc++; @(negedge clk); end
    txclk_lvl = 1;
    repeat (2) @(negedge clk);
    chk(cyc == WR, "R9 clock drop keeps length", cyc, WR);
    chk(wcount - w0 == 2, "R9 writes completed", wcount - w0, 2);
    chk(mism() == 0, "R4 busy strobes ignored", mism(), 0);
    do_stop(b);
    chk(b == 0, "R10 stop without load", b, 0);

    // R10: load then stop with no data
    do_load(7'h48);
    do_stop(b);
    chk(b == 0, "R10 empty transfer", b, 0);

    // R1: a second address load discards earlier bytes
    w0 = wcount;
    do_load(7'h50); do_byte(8'hAA, 1);
    do_load(7'h58); do_byte(8'hBB, 1);
    model[7'h58] = 8'hBB;
    do_stop(b);
    wait_idle(cyc);
    chk(wcount - w0 == 1, "R1 reload discards", wcount - w0, 1);
    chk(mism() == 0, "R1 only new byte stored", mism(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule